// File: doc/BRIEF.md
# Auto-Precharge Timing Tracker

This block watches the command stream leaving a DRAM controller's scheduler. It works out the clock edge at which the memory device closes a bank by itself after a read or write that carried the auto-precharge flag. Each accepted command carries a code, a bank index and a memory-family select. The burst length, the data-rate mode and the latency and recovery times (additive latency, write latency, write recovery, read-to-precharge) are runtime inputs counted in clocks. For every bank the block keeps a down-counter. It raises a pending flag while that counter runs and emits a one-cycle implied-precharge pulse when the counter expires.

Alongside this, the block re-emits each accepted command one cycle later with the auto-precharge flag removed. Downstream accounting logic can then treat RDA as RD and WRA as WR. The delay formula depends on the memory family and on the direction. It uses clamping terms, so different parts of the same controller can share one tracker.

Top module: `apc_tracker`

## Requirements
- R1: Burst duration B equals burst_len when dr_double is 0 and burst_len/2 (rounded down) when dr_double is 1; B enters every delay formula.
- R2: For a read with auto-precharge (code 3), the delay is B+AL-2+max(RTP,2) for family 0, AL+max(RTP,4) for family 1, and AL+RTP for family 2.
- R3: For a read with auto-precharge, the delay is B for families 3 and 6, B+max(0,RTP-2) for family 4, and B+max(0,RTP-4) for family 5.
- R4: For a write with auto-precharge (code 4), the delay is B+WL+WR for families 0 to 2, B+WR for family 3, B+WL+WR+1 for families 4 and 5, and B+WL+WR-1 for family 6.
- R5: Codes other than 3 and 4 (ACT=0, RD=1, WR=2, PRE=5, REF=6, 7) arm no counter, and they leave the state of a bank that is already pending unchanged.
- R6: One cycle after each accepted command, base_vld is high and base_code carries the code, with 3 replaced by 1 and 4 replaced by 2.
- R7: For a delay D of one or more, accepted at edge k, apc_pending of that bank is high from edge k up to edge k+D. The bank's apc_pulse is high for exactly the one cycle after edge k+D, and at that edge apc_pending falls.
- R8: Code 3 or 4 arriving for a bank that is already pending reloads its counter with the new delay. This holds even in the cycle the old count would expire. Exactly one pulse follows, timed from the newest command.
- R9: A delay that computes to zero or below is treated as zero and fires the pulse after the next clock edge, exactly as a delay of one does.
- R10: With rst high at a clock edge, every pending flag, every pulse and base_vld are low after that edge.
- R11: Banks are independent. A command to one bank does not disturb the counter, pending flag or pulse of any other bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_vld | input | 1 | A command is issued this cycle |
| cmd_code | input | 3 | Command code (0 ACT, 1 RD, 2 WR, 3 RDA, 4 WRA, 5 PRE, 6 REF) |
| cmd_bank | input | BW | Target bank of the command |
| mem_family | input | 3 | 0 DDR2, 1 DDR3, 2 DDR4, 3 LPDDR, 4 LPDDR2, 5 LPDDR3, 6 Wide-IO SDR |
| burst_len | input | TW | Burst length in beats |
| dr_double | input | 1 | 1 when two beats transfer per clock |
| add_lat | input | TW | Additive latency (AL) in clocks |
| wr_lat | input | TW | Write latency (WL) in clocks |
| wr_rec | input | TW | Write recovery (WR) in clocks |
| rd_to_pre | input | TW | Read-to-precharge time (RTP) in clocks |
| apc_pulse | output | NB | One-cycle implied precharge, one bit per bank |
| apc_pending | output | NB | Counter running, one bit per bank |
| base_vld | output | 1 | base_code is valid |
| base_code | output | 3 | Accepted command with the auto-precharge flag removed |

## Verification
Two things can fall in the same cycle: a bank's count expiring, and a new auto-precharge command arriving for that bank or for another one. The bench provokes the same-bank case directly. It measures a delay, then reissues to the bank on the exact edge where the old count would fire, and requires a single pulse timed from the second command. It provokes the cross-bank case by issuing to a neighbour on the expiry edge. A long random run with frequent commands and small delays produces both collisions many times. A behavioural model of the rules judges every cycle.

// File: rtl/apc_pkg.sv
package apc_pkg;
  typedef enum logic [2:0] {
    CMD_ACT = 3'd0, CMD_RD = 3'd1, CMD_WR = 3'd2, CMD_RDA = 3'd3,
    CMD_WRA = 3'd4, CMD_PRE = 3'd5, CMD_REF = 3'd6, CMD_NOP = 3'd7
  } cmd_e;

  typedef enum logic [2:0] {
    FAM_D2 = 3'd0, FAM_D3 = 3'd1, FAM_D4 = 3'd2, FAM_LP1 = 3'd3,
    FAM_LP2 = 3'd4, FAM_LP3 = 3'd5, FAM_WIO = 3'd6, FAM_RSV = 3'd7
  } fam_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic [2:0] strip_apc(input logic [2:0] c);
    case (c)
      CMD_RDA: strip_apc = CMD_RD;
      CMD_WRA: strip_apc = CMD_WR;
      default: strip_apc = c;
    endcase
  endfunction
endpackage

// File: rtl/apc_delay_calc.sv
module apc_delay_calc
  import apc_pkg::*;
#(
  parameter int TW = 6,
  parameter int DW = TW + 3
) (
  input  logic [2:0]    cmd_code,
  input  logic [2:0]    mem_family,
  input  logic [TW-1:0] burst_len,
  input  logic          dr_double,
  input  logic [TW-1:0] add_lat,
  input  logic [TW-1:0] wr_lat,
  input  logic [TW-1:0] wr_rec,
  input  logic [TW-1:0] rd_to_pre,
  output logic          is_apc,
  output logic [DW-1:0] delay
);
  int b_i, al_i, wl_i, wr_i, rtp_i, tot;

  always_comb begin
    al_i  = 32'(add_lat);
    wl_i  = 32'(wr_lat);
    wr_i  = 32'(wr_rec);
    rtp_i = 32'(rd_to_pre);
    b_i   = dr_double ? 32'(burst_len >> 1) : 32'(burst_len);
    is_apc = (cmd_code == CMD_RDA) || (cmd_code == CMD_WRA);
    tot = 0;
    if (cmd_code == CMD_RDA) begin
      case (mem_family)
        FAM_D2:  tot = b_i + al_i - 2 + imax(rtp_i, 2);
        FAM_D3:  tot = al_i + imax(rtp_i, 4);
        FAM_D4:  tot = al_i + rtp_i;
        FAM_LP2: tot = b_i + imax(0, rtp_i - 2);
        FAM_LP3: tot = b_i + imax(0, rtp_i - 4);
        default: tot = b_i;
      endcase
    end else if (cmd_code == CMD_WRA) begin
      case (mem_family)
        FAM_LP1:          tot = b_i + wr_i;
        FAM_LP2, FAM_LP3: tot = b_i + wl_i + wr_i + 1;
        FAM_WIO:          tot = b_i + wl_i + wr_i - 1;
        default:          tot = b_i + wl_i + wr_i;
      endcase
    end
    if (tot < 0) tot = 0;
    delay = DW'(tot);
  end
endmodule

// File: rtl/apc_bank_timer.sv
module apc_bank_timer #(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hit,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  output logic          pending,
  output logic          pulse
);
  logic [DW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      pending <= 1'b0;
      pulse   <= 1'b0;
    end else if (load) begin
      cnt     <= load_val;
      pending <= 1'b1;
      pulse   <= 1'b0;
    end else if (pending && cnt == DW'(1)) begin
      cnt     <= '0;
      pending <= 1'b0;
      pulse   <= 1'b1;
    end else begin
      if (pending) cnt <= cnt - DW'(1);
      pulse <= 1'b0;
    end
  end

  assert_pulse_single_R7: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
  assert_pulse_ends_pending_R7: assert property (@(posedge clk) disable iff (rst)
    pulse |-> (!pending && $past(pending)));
  assert_reload_R8: assert property (@(posedge clk) disable iff (rst)
    load |=> (pending && !pulse));
  assert_no_arm_R5: assert property (@(posedge clk) disable iff (rst)
    (hit && !load && !pending) |=> (!pending && !pulse));
  assert_load_nonzero_R9: assert property (@(posedge clk) disable iff (rst)
    load |-> (load_val != '0));
endmodule

// File: rtl/apc_tracker.sv
module apc_tracker
  import apc_pkg::*;
#(
  parameter int NB = 8,
  parameter int TW = 6,
  localparam int BW = (NB > 1) ? $clog2(NB) : 1,
  localparam int DW = TW + 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_vld,
  input  logic [2:0]    cmd_code,
  input  logic [BW-1:0] cmd_bank,
  input  logic [2:0]    mem_family,
  input  logic [TW-1:0] burst_len,
  input  logic          dr_double,
  input  logic [TW-1:0] add_lat,
  input  logic [TW-1:0] wr_lat,
  input  logic [TW-1:0] wr_rec,
  input  logic [TW-1:0] rd_to_pre,
  output logic [NB-1:0] apc_pulse,
  output logic [NB-1:0] apc_pending,
  output logic          base_vld,
  output logic [2:0]    base_code
);
  logic          is_apc;
  logic [DW-1:0] delay;
  logic [DW-1:0] load_val;

  apc_delay_calc #(.TW(TW), .DW(DW)) u_calc (
    .cmd_code  (cmd_code),
    .mem_family(mem_family),
    .burst_len (burst_len),
    .dr_double (dr_double),
    .add_lat   (add_lat),
    .wr_lat    (wr_lat),
    .wr_rec    (wr_rec),
    .rd_to_pre (rd_to_pre),
    .is_apc    (is_apc),
    .delay     (delay)
  );

  // zero delay behaves as one: fire after the next edge
  assign load_val = (delay == '0) ? DW'(1) : delay;

  for (genvar g = 0; g < NB; g++) begin : g_bank
    logic hit_g;
    assign hit_g = cmd_vld && (cmd_bank == BW'(g));
    apc_bank_timer #(.DW(DW)) u_tmr (
      .clk     (clk),
      .rst     (rst),
      .hit     (hit_g),
      .load    (hit_g && is_apc),
      .load_val(load_val),
      .pending (apc_pending[g]),
      .pulse   (apc_pulse[g])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_vld  <= 1'b0;
      base_code <= CMD_ACT;
    end else begin
      base_vld  <= cmd_vld;
      base_code <= strip_apc(cmd_code);
    end
  end

  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> (apc_pulse == '0 && apc_pending == '0 && !base_vld));
  assert_base_stripped_R6: assert property (@(posedge clk) disable iff (rst)
    base_vld |-> (base_code != CMD_RDA && base_code != CMD_WRA));
  assert_base_follows_R6: assert property (@(posedge clk) disable iff (rst)
    cmd_vld |=> base_vld);
  assert_pulse_pending_excl_R7: assert property (@(posedge clk) disable iff (rst)
    (apc_pulse & apc_pending) == '0);
endmodule

// File: tb/test_apc_tracker.sv
module test_apc_tracker;
  localparam int NB = 8;
  localparam int TW = 6;
  localparam int BW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_vld = 1'b0;
  logic [2:0] cmd_code = '0;
  logic [BW-1:0] cmd_bank = '0;
  logic [2:0] mem_family = '0;
  logic [TW-1:0] burst_len = 6'd8;
  logic dr_double = 1'b1;
  logic [TW-1:0] add_lat = '0, wr_lat = '0, wr_rec = '0, rd_to_pre = '0;
  logic [NB-1:0] apc_pulse, apc_pending;
  logic base_vld;
  logic [2:0] base_code;

  int checks = 0;
  int fails = 0;
  bit started = 0;
  bit done = 0;

  always #4 clk = ~clk;

  apc_tracker #(.NB(NB), .TW(TW)) i_apc_tracker (
    .clk(clk), .rst(rst), .cmd_vld(cmd_vld), .cmd_code(cmd_code),
    .cmd_bank(cmd_bank), .mem_family(mem_family), .burst_len(burst_len),
    .dr_double(dr_double), .add_lat(add_lat), .wr_lat(wr_lat),
    .wr_rec(wr_rec), .rd_to_pre(rd_to_pre), .apc_pulse(apc_pulse),
    .apc_pending(apc_pending), .base_vld(base_vld), .base_code(base_code)
  );

  function automatic int mx(int a, int b);
    return (a > b) ? a : b;
  endfunction

  // delay rules written from the requirements (R1-style B, then per family)
  function automatic int ref_delay(int c, int f, int bl, int dd, int al, int wl, int wr, int rtp);
    int b = dd ? bl / 2 : bl;
    int t = 0;
    if (c == 3) begin
      if (f == 0) t = b + al - 2 + mx(rtp, 2);
      else if (f == 1) t = al + mx(rtp, 4);
      else if (f == 2) t = al + rtp;
      else if (f == 4) t = b + mx(0, rtp - 2);
      else if (f == 5) t = b + mx(0, rtp - 4);
      else t = b;
    end else if (c == 4) begin
      if (f == 3) t = b + wr;
      else if (f == 4 || f == 5) t = b + wl + wr + 1;
      else if (f == 6) t = b + wl + wr - 1;
      else t = b + wl + wr;
    end
    return (t < 0) ? 0 : t;
  endfunction

  // behavioural reference model
  int m_cnt[NB];
  bit m_pend[NB];
  bit m_pulse[NB];
  bit m_bvld;
  int m_base;

  always @(posedge clk) begin
    started <= 1;
    if (rst) begin
      for (int b = 0; b < NB; b++) begin m_cnt[b] = 0; m_pend[b] = 0; m_pulse[b] = 0; end
      m_bvld = 0; m_base = 0;
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (cmd_vld && int'(cmd_bank) == b && (cmd_code == 3 || cmd_code == 4)) begin
          m_cnt[b] = mx(1, ref_delay(int'(cmd_code), int'(mem_family), int'(burst_len),
                      int'(dr_double), int'(add_lat), int'(wr_lat), int'(wr_rec), int'(rd_to_pre)));
          m_pend[b] = 1; m_pulse[b] = 0;
        end else if (m_pend[b] && m_cnt[b] == 1) begin
          m_pend[b] = 0; m_pulse[b] = 1; m_cnt[b] = 0;
        end else begin
          if (m_pend[b]) m_cnt[b]--;
          m_pulse[b] = 0;
        end
      end
      m_bvld = cmd_vld;
      m_base = (cmd_code == 3) ? 1 : (cmd_code == 4) ? 2 : int'(cmd_code);
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      for (int b = 0; b < NB; b++) begin
        checks++;
        if (apc_pulse[b] !== m_pulse[b] || apc_pending[b] !== m_pend[b]) begin
          fails++;
          $display("FAIL R7/R8/R11 bank %0d: pulse=%b pend=%b expected pulse=%b pend=%b at %0t",
                   b, apc_pulse[b], apc_pending[b], m_pulse[b], m_pend[b], $time);
        end
      end
      checks++;
      if (base_vld !== m_bvld || (m_bvld && int'(base_code) != m_base)) begin
        fails++;
        $display("FAIL R6: vld=%b code=%0d expected vld=%b code=%0d", base_vld, base_code, m_bvld, m_base);
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_t(int f, int bl, int dd, int al, int wl, int wr, int rtp);
    mem_family = 3'(f); burst_len = TW'(bl); dr_double = dd[0];
    add_lat = TW'(al); wr_lat = TW'(wl); wr_rec = TW'(wr); rd_to_pre = TW'(rtp);
  endtask

  task automatic issue(int c, int b);
    cmd_vld = 1; cmd_code = 3'(c); cmd_bank = BW'(b);
    @(negedge clk);
    cmd_vld = 0;
  endtask

  // issue an auto-precharge command and count edges until its pulse
  task automatic measure(string tag, int c, int b, int exp);
    int n = 0;
    issue(c, b);
    do begin
      @(negedge clk); n++;
    end while (!apc_pulse[b] && n < 300);
    check(tag, n, exp);
    @(negedge clk);
  endtask

  initial begin
    #1_200_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int seen;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 pending", int'(apc_pending), 0);
    check("R10 pulse", int'(apc_pulse), 0);
    rst = 0;
    @(negedge clk);

    // R1: double vs single data rate, DDR4 write: B+WL+WR
    set_t(2, 8, 1, 0, 3, 2, 0); measure("R1 R4 ddr4 wra dd", 4, 0, 9);
    set_t(2, 8, 0, 0, 3, 2, 0); measure("R1 R4 ddr4 wra sd", 4, 0, 13);
    // R2: read formulas of the DDR families
    set_t(0, 8, 1, 1, 0, 0, 1); measure("R2 ddr2 rda", 3, 1, 5);
    set_t(1, 8, 1, 1, 0, 0, 3); measure("R2 ddr3 rda clamp", 3, 1, 5);
    set_t(2, 8, 1, 2, 0, 0, 7); measure("R2 ddr4 rda", 3, 2, 9);
    // R3: read formulas of the low-power and wide-IO families
    set_t(4, 8, 1, 0, 0, 0, 5); measure("R3 lp2 rda", 3, 3, 7);
    set_t(5, 8, 1, 0, 0, 0, 2); measure("R3 lp3 rda clamp", 3, 3, 4);
    set_t(3, 6, 0, 0, 0, 0, 9); measure("R3 lp1 rda", 3, 4, 6);
    // R4: write formulas
    set_t(3, 4, 1, 0, 9, 3, 0); measure("R4 lp1 wra", 4, 5, 5);
    set_t(5, 4, 1, 0, 2, 3, 0); measure("R4 lp3 wra", 4, 5, 8);
    set_t(6, 4, 1, 0, 2, 3, 0); measure("R4 wio wra", 4, 6, 6);
    // R9: total below zero and total zero both fire after the next edge
    set_t(6, 0, 1, 0, 0, 0, 0); measure("R9 wio negative", 4, 7, 1);
    set_t(3, 1, 1, 0, 0, 0, 0); measure("R9 lp1 zero", 3, 7, 1);

    // R5: plain commands arm nothing and leave a pending bank alone
    set_t(1, 8, 1, 0, 0, 0, 4);
    for (int c = 0; c < 8; c++) if (c != 3 && c != 4) issue(c, 2);
    @(negedge clk);
    check("R5 no arm", int'(apc_pending), 0);
    issue(3, 2);
    issue(5, 2); issue(0, 2);
    check("R5 pending kept", int'(apc_pending[2]), 1);
    repeat (6) @(negedge clk);

    // R6: stripped code one cycle after the command
    cmd_vld = 1; cmd_code = 3'd4; cmd_bank = 0;
    @(negedge clk); cmd_vld = 0;
    check("R6 wra->wr", int'(base_code), 2);
    repeat (10) @(negedge clk);

    // R8: reload on the expiry edge, one pulse timed from the new command
    set_t(1, 8, 1, 0, 0, 0, 0);          // delay 4
    issue(3, 0);                          // edge k
    repeat (3) @(negedge clk);            // next issue lands on edge k+4
    set_t(2, 8, 1, 3, 0, 0, 3);          // delay 6
    issue(3, 0);
    // R11: neighbour issued while bank 0 reloads
    issue(4, 1);
    seen = 0;
    for (int i = 0; i < 12; i++) begin
      if (apc_pulse[0]) seen++;
      @(negedge clk);
    end
    check("R8 single pulse", seen, 1);
    check("R11 idle", int'(apc_pending), 0);

    // random run judged by the model (R7, R8, R11 collisions)
    for (int i = 0; i < 4000; i++) begin
      if (i % 150 == 0)
        set_t($urandom_range(6), $urandom_range(16), $urandom_range(1), $urandom_range(4),
              $urandom_range(5), $urandom_range(6), $urandom_range(8));
      cmd_vld = ($urandom_range(3) != 0);
      cmd_code = 3'($urandom_range(7));
      cmd_bank = BW'($urandom_range(NB - 1));
      rst = ($urandom_range(999) == 0);
      @(negedge clk);
    end
    cmd_vld = 0; rst = 1;
    @(negedge clk);
    // R10: synchronous reset clears everything
    check("R10 after reset", int'(apc_pending) + int'(apc_pulse) + int'(base_vld), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule